// File: doc/BRIEF.md
# Reservation Tracker for Load-Reserved / Store-Conditional

This per-hart unit handles the reservation behind a load-reserved / store-conditional pair. An aligned load-reserved opens a reservation on the aligned 8-byte granule that holds its address. A later store-conditional writes memory only when that reservation still covers its granule. The core gets back a result code: 0 on success, 1 on failure. The reservation is gone after every aligned store-conditional, whether it succeeded or not.

A snoop port reports stores made by other harts. Any such store that touches a byte of the reserved granule cancels the reservation, so no foreign store can land between a load-reserved and the store-conditional that completes it. A separate drop input lets the core throw the reservation away for reasons of its own. An access that is not aligned to its size raises an exception and is not executed.

Every response, the memory write strobe and the reservation flag are registered. They appear one clock after the request.

Top module: `lrsc_resv_tracker`

## Requirements
- R1: After reset no reservation is held, and `rsp_valid` and `mem_we` are low.
- R2: An aligned load-reserved gives `rsp_valid` with `rsp_exc`=0 and `rsp_code`=0 on the next cycle, and `resv_valid` then reads 1.
- R3: A store-conditional succeeds when a reservation is held and the store falls in the same 8-byte granule (address bits above bit 2 are equal), with no snoop hit and no drop in that cycle. It then responds with code 0 and raises `mem_we` one cycle later, with `mem_addr`/`mem_wdata` carrying the request's address and data.
- R4: A store-conditional with no reservation held fails: code 1, `mem_we` stays 0.
- R5: Every aligned store-conditional leaves `resv_valid` at 0, whatever its outcome.
- R6: A store-conditional to a granule other than the reserved one fails with code 1.
- R7: A snooped store of 2^`snp_lgbytes` bytes starting at `snp_addr` clears the reservation when any of its bytes lies in the reserved granule, including a store that straddles the granule boundary. A snooped store outside the granule leaves the reservation intact.
- R8: A `drop_req` pulse clears the reservation. A load-reserved in the same cycle as the pulse does not set a reservation.
- R9: When a snoop hit and a store-conditional arrive in the same cycle, the snoop wins: the store-conditional fails with code 1 and no write.
- R10: A word access (`req_dword`=0) must be 4-byte aligned and a doubleword access must be 8-byte aligned. A misaligned request responds with `rsp_exc`=1 and code 0, performs no write, and leaves the reservation unchanged.
- R11: A new load-reserved replaces any earlier reservation, so a store-conditional to the old granule then fails.
- R12: A snoop that hits the granule of a load-reserved in the same cycle leaves no reservation behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request from the core this cycle |
| req_is_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_dword | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Store-conditional write data |
| snp_valid | input | 1 | A store from another hart is reported |
| snp_addr | input | AW | Start byte address of the snooped store |
| snp_lgbytes | input | 2 | log2 of the snooped store size (1 to 8 bytes) |
| drop_req | input | 1 | Local request to abandon the reservation |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_exc | output | 1 | Misalignment exception |
| rsp_code | output | CODE_W | Result code: 0 success, 1 failure |
| mem_we | output | 1 | Store-conditional write to memory |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| resv_valid | output | 1 | A reservation is currently held |

## Verification
The hardest cases to reach are the same-cycle collisions: a snoop arriving together with the store-conditional it must defeat, or together with a load-reserved to the granule it hits. A third hard case is a snooped store that starts in the granule below and spills into the reserved one. The vector table places each snoop and drop in the same row as the request, so each collision happens on one exact edge. The straddling case uses an 8-byte snoop that starts four bytes before the reserved granule. Misaligned requests are sent while a reservation is held, and a later successful store-conditional then shows the reservation survived them.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  // Result codes returned to the core for a store-conditional.
  localparam int unsigned SC_PASS = 0;
  localparam int unsigned SC_FAIL = 1;

  // Natural alignment check on the low three address bits.
  function automatic logic req_misaligned(input logic [2:0] lo, input logic dword);
    return dword ? (lo != 3'd0) : (lo[1:0] != 2'd0);
  endfunction

  // Number of extra bytes beyond the first for a 2^lg byte store.
  function automatic logic [3:0] span_extra(input logic [1:0] lg);
    return (4'd1 << lg) - 4'd1;
  endfunction

endpackage

// File: rtl/lrsc_snoop_match.sv
module lrsc_snoop_match import lrsc_pkg::*; #(
  parameter int AW      = 32,
  parameter int GRAN_LG = 3,
  parameter int NG      = 2
) (
  input  logic [AW-1:0]                 snp_addr,
  input  logic [1:0]                    snp_lgbytes,
  input  logic [NG-1:0][AW-GRAN_LG-1:0] gran,
  output logic [NG-1:0]                 hit
);
  localparam int GW = AW - GRAN_LG;

  logic [AW-1:0] last_byte;
  logic [GW-1:0] first_g, last_g;

  assign last_byte = snp_addr + AW'(span_extra(snp_lgbytes));
  assign first_g   = snp_addr[AW-1:GRAN_LG];
  assign last_g    = last_byte[AW-1:GRAN_LG];

  // A store no wider than a granule touches at most two granules.
  for (genvar g = 0; g < NG; g++) begin : g_cmp
    assign hit[g] = (first_g == gran[g]) || (last_g == gran[g]);
  end
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int GW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [GW-1:0] set_gran,
  output logic          valid_q,
  output logic [GW-1:0] gran_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else if (set) begin
      valid_q <= 1'b1;
      gran_q  <= set_gran;
    end else if (clr) begin
      valid_q <= 1'b0;
    end
  end

  // R2: a set opens the reservation on the requested granule
  a_r2_set_opens: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (valid_q && gran_q == $past(set_gran)));
endmodule

// File: rtl/lrsc_resv_tracker.sv
module lrsc_resv_tracker import lrsc_pkg::*; #(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int CODE_W  = 8,
  parameter int GRAN_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_sc,
  input  logic              req_dword,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              snp_valid,
  input  logic [AW-1:0]     snp_addr,
  input  logic [1:0]        snp_lgbytes,
  input  logic              drop_req,
  output logic              rsp_valid,
  output logic              rsp_exc,
  output logic [CODE_W-1:0] rsp_code,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              resv_valid
);
  localparam int GW = AW - GRAN_LG;

  // Named internal events
  logic          misal, lr_go, sc_go, bad_req;
  logic          hit_cur, hit_new, sc_pass, resv_set, resv_clr;
  logic [GW-1:0] req_gran, gran_q;
  logic [1:0]    hits;

  assign req_gran = req_addr[AW-1:GRAN_LG];
  assign misal    = req_misaligned(req_addr[2:0], req_dword);
  assign lr_go    = req_valid && !req_is_sc && !misal;
  assign sc_go    = req_valid &&  req_is_sc && !misal;
  assign bad_req  = req_valid && misal;

  lrsc_snoop_match #(.AW(AW), .GRAN_LG(GRAN_LG), .NG(2)) u_snoop (
    .snp_addr    (snp_addr),
    .snp_lgbytes (snp_lgbytes),
    .gran        ({req_gran, gran_q}),
    .hit         (hits)
  );

  assign hit_cur  = snp_valid && resv_valid && hits[0];
  assign hit_new  = snp_valid && hits[1];
  assign sc_pass  = sc_go && resv_valid && (req_gran == gran_q) && !hit_cur && !drop_req;
  assign resv_set = lr_go && !hit_new && !drop_req;
  assign resv_clr = hit_cur || drop_req || sc_go || lr_go;

  lrsc_resv_reg #(.GW(GW)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (resv_set),
    .clr      (resv_clr),
    .set_gran (req_gran),
    .valid_q  (resv_valid),
    .gran_q   (gran_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_exc   <= 1'b0;
      rsp_code  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_exc   <= bad_req;
      rsp_code  <= (sc_go && !sc_pass) ? CODE_W'(SC_FAIL) : CODE_W'(SC_PASS);
      mem_we    <= sc_pass;
      if (sc_pass) begin
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
      end
    end
  end

  // R3: a write only follows a held reservation
  a_r3_write_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(resv_valid));
  // R4: store-conditional without reservation never writes
  a_r4_no_resv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_go && !resv_valid) |=> (!mem_we && rsp_code != '0));
  // R5: reservation is gone after any aligned store-conditional
  a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_go |=> !resv_valid);
  // R7: a snoop hit on the held granule removes it unless a new LR re-arms it
  a_r7_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cur && !resv_set) |=> !resv_valid);
  // R9: snoop wins over a same-cycle store-conditional
  a_r9_snoop_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cur && sc_go) |=> (!mem_we && rsp_code != '0));
  // R10: an exception never comes with a write, and keeps the reservation
  a_r10_exc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> !mem_we);
  a_r10_exc_keeps_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_req && !snp_valid && !drop_req) |=> (resv_valid == $past(resv_valid)));
  // R12: same-cycle snoop on the LR granule leaves nothing reserved
  a_r12_snoop_beats_lr: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_go && hit_new) |=> !resv_valid);
endmodule

// File: tb/sim_lrsc_resv_tracker.sv
module sim_lrsc_resv_tracker;
  localparam int AW = 32, DW = 64, CODE_W = 8;
  localparam logic T = 1'b1, F = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_sc = 1'b0, req_dword = 1'b0;
  logic [AW-1:0] req_addr = '0, snp_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic snp_valid = 1'b0, drop_req = 1'b0;
  logic [1:0] snp_lgbytes = 2'd0;
  logic rsp_valid, rsp_exc, mem_we, resv_valid;
  logic [CODE_W-1:0] rsp_code;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  lrsc_resv_tracker u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // rq: requirement tag; v sc dw addr; sv saddr slg; drop; expected rv exc code we resv
  typedef struct packed {
    logic [3:0]  rq;
    logic        v, sc, dw;
    logic [31:0] a;
    logic        sv;
    logic [31:0] sa;
    logic [1:0]  sl;
    logic        dr;
    logic        ev, ex, ec, ew, er;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [0:NV-1] = '{
    '{4'd2,  T,F,T,32'h100, F,32'h0,2'd0, F, T,F,F,F,T}, // R2 LR
    '{4'd3,  T,T,T,32'h100, F,32'h0,2'd0, F, T,F,F,T,F}, // R3 SC ok, R5 clear
    '{4'd4,  T,T,T,32'h100, F,32'h0,2'd0, F, T,F,T,F,F}, // R4 no resv
    '{4'd2,  T,F,F,32'h204, F,32'h0,2'd0, F, T,F,F,F,T}, // R2 word LR
    '{4'd3,  T,T,F,32'h200, F,32'h0,2'd0, F, T,F,F,T,F}, // R3 same granule
    '{4'd2,  T,F,T,32'h300, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd6,  T,T,T,32'h308, F,32'h0,2'd0, F, T,F,T,F,F}, // R6 other granule
    '{4'd2,  T,F,T,32'h400, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd7,  F,F,F,32'h0,   T,32'h404,2'd2, F, F,F,F,F,F}, // R7 inside hit
    '{4'd2,  T,F,T,32'h500, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd7,  F,F,F,32'h0,   T,32'h4FC,2'd3, F, F,F,F,F,F}, // R7 straddle
    '{4'd2,  T,F,T,32'h600, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd7,  F,F,F,32'h0,   T,32'h608,2'd3, F, F,F,F,F,T}, // R7 miss above
    '{4'd7,  F,F,F,32'h0,   T,32'h5FF,2'd0, F, F,F,F,F,T}, // R7 miss below
    '{4'd7,  T,T,T,32'h600, F,32'h0,2'd0, F, T,F,F,T,F}, // R7 survived
    '{4'd2,  T,F,T,32'h700, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd8,  F,F,F,32'h0,   F,32'h0,2'd0, T, F,F,F,F,F}, // R8 drop
    '{4'd8,  T,T,T,32'h700, F,32'h0,2'd0, F, T,F,T,F,F},
    '{4'd2,  T,F,T,32'h800, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd9,  T,T,T,32'h800, T,32'h802,2'd1, F, T,F,T,F,F}, // R9 collision
    '{4'd2,  T,F,T,32'h900, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd10, T,F,F,32'h902, F,32'h0,2'd0, F, T,T,F,F,T}, // R10 word misal
    '{4'd10, T,T,T,32'h904, F,32'h0,2'd0, F, T,T,F,F,T}, // R10 dword misal
    '{4'd10, T,T,T,32'h900, F,32'h0,2'd0, F, T,F,F,T,F}, // R10 resv kept
    '{4'd2,  T,F,T,32'hA00, F,32'h0,2'd0, F, T,F,F,F,T},
    '{4'd11, T,F,T,32'hB00, F,32'h0,2'd0, F, T,F,F,F,T}, // R11 replace
    '{4'd11, T,T,T,32'hA00, F,32'h0,2'd0, F, T,F,T,F,F},
    '{4'd12, T,F,T,32'hC00, T,32'hC04,2'd2, F, T,F,F,F,F}, // R12
    '{4'd8,  T,F,T,32'hD00, F,32'h0,2'd0, T, T,F,F,F,F}  // R8 drop vs LR
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle();
    req_valid = 0; req_is_sc = 0; req_dword = 0; req_addr = '0; req_wdata = '0;
    snp_valid = 0; snp_addr = '0; snp_lgbytes = 2'd0; drop_req = 0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {125'd0, resv_valid, rsp_valid, mem_we}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {126'd0, resv_valid, mem_we}, 128'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t e;
      logic [DW-1:0] wd;
      e = TBL[i];
      wd = {16'hC0DE, 16'(i), e.a};
      req_valid = e.v; req_is_sc = e.sc; req_dword = e.dw; req_addr = e.a; req_wdata = wd;
      snp_valid = e.sv; snp_addr = e.sa; snp_lgbytes = e.sl; drop_req = e.dr;
      @(negedge clk);
      check($sformatf("R%0d vec%0d rv/exc/we/resv", e.rq, i),
            {124'd0, rsp_valid, rsp_exc, mem_we, resv_valid},
            {124'd0, e.ev, e.ex, e.ew, e.er});
      if (e.ev && !e.ex)
        check($sformatf("R%0d vec%0d code", e.rq, i), 128'(rsp_code), 128'(e.ec));
      if (e.ew)
        check($sformatf("R3 vec%0d write addr/data", i), {32'd0, mem_addr, mem_wdata}, {32'd0, e.a, wd});
    end

    // R1: reset in the middle drops a held reservation
    idle();
    req_valid = 1; req_dword = 1; req_addr = 32'hE00;
    @(negedge clk);
    idle();
    check("R2 LR before reset", 128'(resv_valid), 128'd1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("R1 reset clears reservation", {126'd0, resv_valid, rsp_valid}, 128'd0);
    req_valid = 1; req_is_sc = 1; req_dword = 1; req_addr = 32'hE00;
    @(negedge clk);
    idle();
    check("R4 SC after reset fails", {127'd0, mem_we}, 128'd0);
    check("R4 SC after reset code", 128'(rsp_code), 128'd1);
    @(negedge clk);
    summary();
  end
endmodule